// File: doc/BRIEF.md
# Line 21 Closed Caption Serializer

This block places two caption characters per field onto one vertical-blanking line as a serial bit stream. It keeps a pair of 7-bit characters for each of the two fields. When a horizontal reference pulse arrives on the caption line of an enabled field, it waits a fixed number of clocks, then sends the burst. The burst is a seven-cycle clock run-in, a 0-0-1 start pattern, and then the two characters. Each character goes out least significant bit first and carries an odd parity bit in bit 7. The output is a one-bit digital caption level plus an active flag. A later stage scales the level and adds it into luma.

The caption bit rate is 32 times the line rate, so at 1716 clocks per line one bit lasts a fractional 53.625 clocks. A modulo accumulator makes half-bit ticks from this. The run-in then alternates once per half bit, and each data bit spans two ticks.

Each field has a status bit. It is high when that field holds no unsent data: after reset, and after a frame that carried freshly written data. Writing either character of a field clears its status. A frame sent while the status is high carries null characters (0x80) in both byte positions.

The sequencer is a Moore machine with these states:
- IDLE: the ready state.
- WAIT: counts the start delay.
- RUNIN: sends the run-in.
- START: sends the start pattern.
- BYTE1: sends the first character.
- BYTE2: sends the second character.

Its transitions are:
- IDLE→WAIT on an accepted trigger.
- WAIT→RUNIN when the delay count expires.
- RUNIN→START, START→BYTE1 and BYTE1→BYTE2 on the tick that closes the last half bit of the section.
- BYTE2→IDLE on the tick that closes the final half bit, which is also the "frame done" event.

Top module: `cc_line21_enc`

## Requirements
- R1: After reset cap_level and cap_active are 0 and sent is 2'b11 (both fields hold no unsent data).
- R2: A clock edge at which h_ref is 1 and the sequencer is idle triggers a frame when line_num equals 21 and field_en[0] is 1 (field 1), or when line_num equals 284 and field_en[1] is 1 (field 2). cap_active rises START_DLY (260) edges after the trigger edge. On any other line, or for a disabled field, nothing is sent and sent does not change.
- R3: Counting j edges from the rise of cap_active, the half-bit index on cap_level is floor(j*64/1716). cap_active stays high for exactly 52 half bits, which is 1395 clocks.
- R4: Half bits 0..13 form the run-in: seven cycles, each one half bit at 1 followed by one half bit at 0.
- R5: Bit periods 7, 8 and 9 (half bits 14..19) carry the start pattern 0, 0, 1.
- R6: Bit periods 10..17 carry byte 1 (slot 0), bits 0..7 in that order. Bit periods 18..25 carry byte 2 (slot 1) in the same way. Bit 7 of each byte is set so that the byte has an odd number of ones.
- R7: A frame triggered while the field's sent bit is 1 sends 0x80 as both bytes.
- R8: wr_en=1 stores wr_char into field wr_field (0 = field 1, 1 = field 2), slot wr_slot (0 = byte 1, 1 = byte 2). It also clears sent[wr_field] at the same edge.
- R9: sent[f] sets at the edge where cap_active falls, for a frame of field f that started with sent[f]=0 and saw no write to field f during the frame. Otherwise sent changes only through writes.
- R10: Both bytes are captured at the trigger, so a write during a frame does not alter the waveform being sent.
- R11: An h_ref pulse on a caption line while a frame is in progress is ignored.
- R12: cap_level is 0 whenever cap_active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_ref | input | 1 | One-clock horizontal reference pulse at line start |
| line_num | input | LINE_W | Current line number from the timing generator |
| field_en | input | 2 | Caption enable, bit 0 field 1, bit 1 field 2 |
| wr_en | input | 1 | Character write strobe |
| wr_field | input | 1 | Field selected by a write |
| wr_slot | input | 1 | Byte position selected by a write |
| wr_char | input | 7 | Character written |
| cap_level | output | 1 | Digital caption level to be summed into luma |
| cap_active | output | 1 | High while the caption burst is on the line |
| sent | output | 2 | Per-field status, 1 = no unsent data |

## Verification
On every cycle, the assertions check the following:
- The caption level stays quiet outside a burst.
- Each burst opens on a high run-in half bit.
- Every burst lasts exactly the computed number of clocks.
- A write clears its field's status on the next cycle.
- A status bit only rises at the end of a burst and is otherwise steady without writes.

Only the bench's scenarios can show that the bit values are right. This covers the run-in, the start pattern, LSB-first order, parity and nulls. The bench also shows that the trigger delay and line matching are right, that per-field enables work, that bytes are captured at the trigger despite a write in mid-frame, and that a repeated reference is ignored.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int CHAR_W = 7;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CC_NULL_BYTE = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUNIN,
        ST_START,
        ST_BYTE1,
        ST_BYTE2
    } cc_state_t;

    // odd parity in bit 7: total count of ones in the byte is odd
    function automatic logic [BYTE_W-1:0] cc_pack(input logic [CHAR_W-1:0] ch);
        return {~(^ch), ch};
    endfunction

endpackage

// File: rtl/cc_half_timer.sv
module cc_half_timer #(
    parameter int LINE_CLKS     = 1716,
    parameter int BITS_PER_LINE = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int STEP = 2 * BITS_PER_LINE;
    localparam int AW   = $clog2(LINE_CLKS + STEP);

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;

    always_comb begin
        sum  = acc + AW'(STEP);
        tick = run && (sum >= AW'(LINE_CLKS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (run) begin
            acc <= tick ? (sum - AW'(LINE_CLKS)) : sum;
        end
    end

endmodule

// File: rtl/cc_char_bank.sv
module cc_char_bank
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_field,
    input  logic              wr_slot,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              arm,
    input  logic              arm_field,
    input  logic              done,
    output logic [BYTE_W-1:0] byte1,
    output logic [BYTE_W-1:0] byte2,
    output logic [1:0]        sent
);
    logic [1:0][1:0][CHAR_W-1:0] chars;

    for (genvar f = 0; f < 2; f++) begin : g_field
        logic [1:0][CHAR_W-1:0] slot_q;
        logic                   sent_q;
        logic                   armed_q;
        logic                   hit;

        assign hit = wr_en && (wr_field == 1'(f));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q  <= '0;
                sent_q  <= 1'b1;
                armed_q <= 1'b0;
            end else if (hit) begin
                slot_q[wr_slot] <= wr_char;
                sent_q          <= 1'b0;
                armed_q         <= 1'b0;
            end else begin
                if (arm && (arm_field == 1'(f)) && !sent_q) begin
                    armed_q <= 1'b1;
                end
                if (done && armed_q) begin
                    sent_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end

        assign chars[f] = slot_q;
        assign sent[f]  = sent_q;
    end

    always_comb begin
        if (sent[arm_field]) begin
            byte1 = CC_NULL_BYTE;
            byte2 = CC_NULL_BYTE;
        end else begin
            byte1 = cc_pack(chars[arm_field][0]);
            byte2 = cc_pack(chars[arm_field][1]);
        end
    end

endmodule

// File: rtl/cc_frame_seq.sv
module cc_frame_seq
    import cc_pkg::*;
#(
    parameter int START_DLY = 260,
    parameter int RUNIN_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              tick,
    input  logic [BYTE_W-1:0] byte1_in,
    input  logic [BYTE_W-1:0] byte2_in,
    output logic              ready,
    output logic              timer_clear,
    output logic              timer_run,
    output logic              done,
    output logic              cap_level,
    output logic              cap_active
);
    localparam int RUNIN_END = 2 * RUNIN_CYC;
    localparam int START_END = RUNIN_END + 6;
    localparam int B1_END    = START_END + 2 * BYTE_W;
    localparam int TOTAL     = B1_END + 2 * BYTE_W;
    localparam int HC_W      = $clog2(TOTAL + 1);
    localparam int DLY_W     = $clog2(START_DLY + 1);

    cc_state_t              state, state_nx;
    logic [DLY_W-1:0]       dly;
    logic [HC_W-1:0]        hc;
    logic [2*BYTE_W-1:0]    data;
    logic [HC_W-1:0]        off;
    logic [3:0]             bsel;

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (trig) state_nx = ST_WAIT;
            ST_WAIT:  if (dly == DLY_W'(START_DLY - 1)) state_nx = ST_RUNIN;
            ST_RUNIN: if (tick && hc == HC_W'(RUNIN_END - 1)) state_nx = ST_START;
            ST_START: if (tick && hc == HC_W'(START_END - 1)) state_nx = ST_BYTE1;
            ST_BYTE1: if (tick && hc == HC_W'(B1_END - 1)) state_nx = ST_BYTE2;
            ST_BYTE2: if (tick && hc == HC_W'(TOTAL - 1)) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dly   <= '0;
            hc    <= '0;
            data  <= '0;
        end else begin
            state <= state_nx;
            dly   <= (state == ST_WAIT) ? dly + 1'b1 : '0;
            if (state == ST_WAIT) begin
                hc <= '0;
            end else if (timer_run && tick) begin
                hc <= hc + 1'b1;
            end
            if (state == ST_IDLE && trig) begin
                data <= {byte2_in, byte1_in};
            end
        end
    end

    // outputs
    always_comb begin
        ready       = 1'b0;
        timer_clear = 1'b0;
        timer_run   = 1'b0;
        cap_level   = 1'b0;
        off         = hc - HC_W'(START_END);
        bsel        = 4'(off >> 1);
        unique case (state)
            ST_IDLE:  ready = 1'b1;
            ST_WAIT:  timer_clear = 1'b1;
            ST_RUNIN: begin
                timer_run = 1'b1;
                cap_level = ~hc[0];
            end
            ST_START: begin
                timer_run = 1'b1;
                cap_level = (hc >= HC_W'(START_END - 2));
            end
            ST_BYTE1, ST_BYTE2: begin
                timer_run = 1'b1;
                cap_level = data[bsel];
            end
            default: ;
        endcase
        cap_active = timer_run;
        done       = (state == ST_BYTE2) && tick && (hc == HC_W'(TOTAL - 1));
    end

endmodule

// File: rtl/cc_line21_enc.sv
module cc_line21_enc
    import cc_pkg::*;
#(
    parameter int LINE_CLKS     = 1716,
    parameter int BITS_PER_LINE = 32,
    parameter int START_DLY     = 260,
    parameter int RUNIN_CYC     = 7,
    parameter int LINE_W        = 10,
    parameter int LINE_F1       = 21,
    parameter int LINE_F2       = 284
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_ref,
    input  logic [LINE_W-1:0] line_num,
    input  logic [1:0]        field_en,
    input  logic              wr_en,
    input  logic              wr_field,
    input  logic              wr_slot,
    input  logic [6:0]        wr_char,
    output logic              cap_level,
    output logic              cap_active,
    output logic [1:0]        sent
);
    logic              on_f1, on_f2, ready, trig, tick;
    logic              timer_clear, timer_run, done;
    logic [BYTE_W-1:0] byte1, byte2;

    assign on_f1 = (line_num == LINE_W'(LINE_F1)) && field_en[0];
    assign on_f2 = (line_num == LINE_W'(LINE_F2)) && field_en[1];
    assign trig  = h_ref && ready && (on_f1 || on_f2);

    cc_char_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_field  (wr_field),
        .wr_slot   (wr_slot),
        .wr_char   (wr_char),
        .arm       (trig),
        .arm_field (on_f2),
        .done      (done),
        .byte1     (byte1),
        .byte2     (byte2),
        .sent      (sent)
    );

    cc_half_timer #(
        .LINE_CLKS     (LINE_CLKS),
        .BITS_PER_LINE (BITS_PER_LINE)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .run   (timer_run),
        .tick  (tick)
    );

    cc_frame_seq #(
        .START_DLY (START_DLY),
        .RUNIN_CYC (RUNIN_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig),
        .tick        (tick),
        .byte1_in    (byte1),
        .byte2_in    (byte2),
        .ready       (ready),
        .timer_clear (timer_clear),
        .timer_run   (timer_run),
        .done        (done),
        .cap_level   (cap_level),
        .cap_active  (cap_active)
    );

endmodule

// File: rtl/cc_line21_chk.sv
module cc_line21_chk #(
    parameter int LINE_CLKS     = 1716,
    parameter int BITS_PER_LINE = 32,
    parameter int RUNIN_CYC     = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_field,
    input logic       cap_level,
    input logic       cap_active,
    input logic [1:0] sent
);
    localparam int STEP     = 2 * BITS_PER_LINE;
    localparam int HALVES   = 2 * RUNIN_CYC + 6 + 32;
    localparam int ACT_CLKS = (HALVES * LINE_CLKS + STEP - 1) / STEP;
    localparam int CW       = $clog2(ACT_CLKS + 2);

    logic [CW-1:0] act_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_cnt <= '0;
        else        act_cnt <= cap_active ? act_cnt + 1'b1 : '0;
    end

    p_quiet_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_active |-> !cap_level);

    p_runin_opens_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_active) |-> cap_level);

    p_burst_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_active) |-> (act_cnt == CW'(ACT_CLKS)));

    p_write_clears_f1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_field) |=> !sent[0]);

    p_write_clears_f2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_field) |=> !sent[1]);

    p_sent_rise_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sent[0]) || $rose(sent[1])) |-> $fell(cap_active));

    p_sent_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && !$fell(cap_active)) |-> $stable(sent));

endmodule

bind cc_line21_enc cc_line21_chk #(
    .LINE_CLKS     (LINE_CLKS),
    .BITS_PER_LINE (BITS_PER_LINE),
    .RUNIN_CYC     (RUNIN_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_field   (wr_field),
    .cap_level  (cap_level),
    .cap_active (cap_active),
    .sent       (sent)
);

// File: tb/cc_line21_enc_test.sv
module cc_line21_enc_test;

    localparam int LC   = 1716;
    localparam int BPL  = 32;
    localparam int SD   = 260;
    localparam int LF1  = 21;
    localparam int LF2  = 284;
    localparam int STEP = 2 * BPL;
    localparam int ACT  = (52 * LC + STEP - 1) / STEP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_ref = 1'b0;
    logic [9:0] line_num = '0;
    logic [1:0] field_en = 2'b00;
    logic       wr_en = 1'b0;
    logic       wr_field = 1'b0;
    logic       wr_slot = 1'b0;
    logic [6:0] wr_char = '0;
    logic       cap_level, cap_active;
    logic [1:0] sent;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 0;
    logic [6:0] ch [2][2];
    bit  pend [2];

    always #4 clk = ~clk;

    cc_line21_enc #(
        .LINE_CLKS(LC), .BITS_PER_LINE(BPL), .START_DLY(SD),
        .LINE_F1(LF1), .LINE_F2(LF2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .h_ref(h_ref), .line_num(line_num),
        .field_en(field_en), .wr_en(wr_en), .wr_field(wr_field),
        .wr_slot(wr_slot), .wr_char(wr_char), .cap_level(cap_level),
        .cap_active(cap_active), .sent(sent)
    );

    function automatic logic [7:0] pack(input logic [6:0] c);
        return {~(^c), c};
    endfunction

    function automatic logic exp_sym(input int h, input logic [7:0] b1, input logic [7:0] b2);
        int b = h / 2;
        if (h < 14)      return (h % 2) == 0;
        else if (b < 10) return b == 9;
        else if (b < 18) return b1[b-10];
        else             return b2[b-18];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_char(input bit f, input bit s, input logic [6:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_field = f; wr_slot = s; wr_char = c;
        @(negedge clk);
        wr_en = 1'b0;
        ch[f][s] = c;
        pend[f] = 1;
        check(sent[f] == 1'b0, "R8 write clears sent", int'(sent[f]), 0);
    endtask

    // one caption line; checks level/active every cycle against the model
    task automatic do_frame(input int line, input bit f, input bit tx,
                            input bit mid_wr, input bit mid_href, input string tag);
        logic [7:0] b1, b2;
        int bad = 0, first_bad = -1, got_lvl = 0, want_lvl = 0, start_at = -1;
        b1 = pend[f] ? pack(ch[f][0]) : 8'h80;
        b2 = pend[f] ? pack(ch[f][1]) : 8'h80;
        @(negedge clk);
        line_num = 10'(line); h_ref = 1'b1;
        @(negedge clk);
        h_ref = 1'b0;
        for (int i = 0; i < SD + ACT + 20; i++) begin
            int j = i - SD;
            logic ea, el;
            ea = tx && (j >= 0) && (j < ACT);
            el = ea ? exp_sym((j * STEP) / LC, b1, b2) : 1'b0;
            if (cap_active && start_at < 0) start_at = i;
            if (cap_active !== ea || cap_level !== el) begin
                bad++;
                if (first_bad < 0) begin
                    first_bad = i; got_lvl = {30'd0, cap_active, cap_level};
                    want_lvl = {30'd0, ea, el};
                end
            end
            wr_en = 1'b0;
            if (mid_wr && i == 500) begin
                wr_en = 1'b1; wr_field = f; wr_slot = 1'b0; wr_char = 7'h55;
            end
            h_ref = (mid_href && i == 700);
            @(negedge clk);
        end
        wr_en = 1'b0; h_ref = 1'b0;
        check(bad == 0, {tag, " waveform R3/R4/R5/R6/R12 {active,level}"}, got_lvl, want_lvl);
        check(start_at == (tx ? SD : -1), {tag, " start delay R2"}, start_at, tx ? SD : -1);
        if (tx && pend[f] && !mid_wr) pend[f] = 0;
        if (mid_wr) begin ch[f][0] = 7'h55; pend[f] = 1; end
        check(sent == {~pend[1], ~pend[0]}, {tag, " status R9"}, int'(sent), int'({~pend[1], ~pend[0]}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C21_0CC5));
        for (int f = 0; f < 2; f++) begin
            pend[f] = 0; ch[f][0] = '0; ch[f][1] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cap_level == 0 && cap_active == 0, "R1 reset outputs", {cap_active, cap_level}, 0);
        check(sent == 2'b11, "R1 reset sent", int'(sent), 3);

        // nulls on both fields
        field_en = 2'b11;
        do_frame(LF1, 0, 1, 0, 0, "R7 null f1");
        do_frame(LF2, 1, 1, 0, 0, "R7 null f2");

        // directed data: parity corners
        write_char(0, 0, 7'h00);
        write_char(0, 1, 7'h7F);
        do_frame(LF1, 0, 1, 0, 0, "R6 parity corners");

        // wrong line and disabled field
        write_char(1, 0, 7'h41);
        write_char(1, 1, 7'h2A);
        do_frame(22, 1, 0, 0, 0, "R2 other line");
        field_en = 2'b01;
        do_frame(LF2, 1, 0, 0, 0, "R2 disabled f2");
        field_en = 2'b11;
        do_frame(LF2, 1, 1, 0, 0, "R2 enabled f2");

        // write during frame and repeated reference
        write_char(0, 0, 7'h13);
        write_char(0, 1, 7'h6C);
        do_frame(LF1, 0, 1, 1, 1, "R10 R11 mid-frame");
        do_frame(LF1, 0, 1, 0, 0, "R10 after mid-frame write");

        // constrained random
        for (int it = 0; it < 14; it++) begin
            for (int f = 0; f < 2; f++)
                for (int s = 0; s < 2; s++)
                    if ($urandom_range(0, 2) != 0)
                        write_char(f[0], s[0], 7'($urandom_range(0, 127)));
            field_en = 2'($urandom_range(0, 3));
            do_frame(LF1, 0, field_en[0], 0, 0, "R6 random f1");
            do_frame(LF2, 1, field_en[1], 0, 0, "R6 random f2");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule